// File: doc/BRIEF.md
# Logical Address Route Resolver

This block turns the leading byte of a packet into a routing decision for a packet switch. A byte below 32 is a path address: it names one output port directly and the configuration table is not used. A byte from 32 to 255 is a logical address: it selects a configurable table entry. Each entry holds a set of output ports, a multicast flag, a group-adaptive flag and a per-port mask that says on which ports the leading address byte is removed before forwarding.

A multicast entry sends the packet to every port of its set. An adaptive entry sends it to the lowest-numbered port of its set that the `port_avail` vector marks free. If no port of the group is free, the request is held and re-evaluated each cycle, and `hdr_ready` stays low. Entries that cannot be routed raise an invalid-route indication so the switch can discard the packet. The result appears on the output record one clock after the header is accepted, or one clock after a free group port appears.

Top module: `rr_route_resolver`

## Requirements
- R1: After reset, `route_valid` is 0 and `hdr_ready` is 1. Every logical table entry is empty, so a lookup of any logical address gives an invalid route.
- R2: A header byte below NPORTS is a path address. One clock after acceptance, `route_ports` is one-hot on the port whose number equals the byte, `route_strip` has that same bit set, and both mode flags are 0.
- R3: A header byte from NPORTS to 31 produces an invalid route.
- R4: A logical entry with only the multicast flag set returns its full port set, `route_mcast`=1, and the strip mask ANDed with the port set.
- R5: A logical entry with only the adaptive flag set returns one port: the lowest-numbered bit of (set AND `port_avail`). It also returns `route_adapt`=1 and the strip bit for that port only.
- R6: If an adaptive entry finds no free port, no result is given and `hdr_ready` drops. `port_avail` is re-evaluated every cycle, and the result appears one clock after a group port becomes free. Headers presented while `hdr_ready` is 0 are ignored.
- R7: An entry gives an invalid route if it has an empty port set, has both mode flags set, or has neither flag set and more than one port. An entry with neither flag set and exactly one port is a plain unicast with both flags 0.
- R8: A table write and a lookup of the same address in the same cycle return the old entry. A later lookup sees the new one.
- R9: Writes with `cfg_addr` below 32 are ignored, and path decoding stays unchanged.
- R10: `route_valid` pulses for one cycle per result. When `route_valid` is 0, or `route_invalid` is 1, the port set, strip mask and mode flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header byte present |
| hdr_byte | input | 8 | Leading packet byte |
| hdr_ready | output | 1 | Block can accept a header (low while adaptive request pending) |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 8 | Logical address to write (32..255) |
| cfg_ports | input | NPORTS | Port set of the entry |
| cfg_strip | input | NPORTS | Per-port header removal flags |
| cfg_mcast | input | 1 | Multicast flag |
| cfg_adapt | input | 1 | Group-adaptive flag |
| port_avail | input | NPORTS | Per-port free indication for adaptive selection |
| route_valid | output | 1 | Result present this cycle |
| route_invalid | output | 1 | Packet cannot be routed |
| route_ports | output | NPORTS | Destination port set |
| route_strip | output | NPORTS | Remove leading byte on these ports |
| route_mcast | output | 1 | Result is a multicast fan-out |
| route_adapt | output | 1 | Result came from an adaptive group |

## Verification
Every cycle, the assertions check the following. An adaptive result names exactly one port, and that port was free in the cycle the choice was made. The strip mask never leaves the port set. An invalid or idle output carries no ports or flags. Multicast and adaptive never appear together. An accepted header gives a result on the next cycle unless it parks as pending.

Some behaviours depend on the table contents and stimulus order, so only the bench scenarios can show them. These are the lowest-free-port choice against a model, the pending wait and ignored headers, the old-data return on a same-cycle write, the ignored writes below 32, and the loss of the table on reset.

// File: rtl/rr_route_pkg.sv
package rr_route_pkg;
   localparam int unsigned HDR_W        = 8;
   localparam int unsigned LOGICAL_BASE = 32;

   typedef enum logic [1:0] {
      KIND_UNICAST  = 2'd0,
      KIND_MULTI    = 2'd1,
      KIND_ADAPTIVE = 2'd2,
      KIND_BAD      = 2'd3
   } route_kind_e;
endpackage

// File: rtl/rr_pick_first.sv
module rr_pick_first #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/rr_path_decode.sv
module rr_path_decode #(
   parameter int unsigned N  = 8,
   parameter int unsigned AW = 8
) (
   input  logic [AW-1:0] addr,
   output logic [N-1:0]  onehot,
   output logic          ok
);
   for (genvar i = 0; i < N; i++) begin : g_dec
      assign onehot[i] = (addr == AW'(i));
   end
   assign ok = |onehot;
endmodule

// File: rtl/rr_route_table.sv
module rr_route_table #(
   parameter int unsigned N    = 8,
   parameter int unsigned AW   = 8,
   parameter int unsigned BASE = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [N-1:0]    wports,
   input  logic [N-1:0]    wstrip,
   input  logic            wmcast,
   input  logic            wadapt,
   input  logic [AW-1:0]   raddr,
   output logic [N-1:0]    rports,
   output logic [N-1:0]    rstrip,
   output logic            rmcast,
   output logic            radapt
);
   localparam int unsigned DEPTH = (1 << AW) - BASE;
   localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned EW    = 2 * N + 2;

   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] woff, roff;
   logic          wsel, rsel;

   assign woff = waddr - AW'(BASE);
   assign roff = raddr - AW'(BASE);
   assign wsel = we && (waddr >= AW'(BASE));
   assign rsel = raddr >= AW'(BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(DEPTH); k++) mem[k] <= '0;
      end else if (wsel) begin
         mem[woff[IW-1:0]] <= {wports, wstrip, wmcast, wadapt};
      end
   end

   logic [EW-1:0] rd;
   assign rd = rsel ? mem[roff[IW-1:0]] : '0;
   assign {rports, rstrip, rmcast, radapt} = rd;
endmodule

// File: rtl/rr_route_resolver.sv
module rr_route_resolver
   import rr_route_pkg::*;
#(
   parameter int unsigned NPORTS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [7:0]        hdr_byte,
   output logic              hdr_ready,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [NPORTS-1:0] cfg_ports,
   input  logic [NPORTS-1:0] cfg_strip,
   input  logic              cfg_mcast,
   input  logic              cfg_adapt,
   input  logic [NPORTS-1:0] port_avail,
   output logic              route_valid,
   output logic              route_invalid,
   output logic [NPORTS-1:0] route_ports,
   output logic [NPORTS-1:0] route_strip,
   output logic              route_mcast,
   output logic              route_adapt
);
   if (NPORTS < 1 || NPORTS > LOGICAL_BASE - 1) begin : g_bad_ports
      $error("rr_route_resolver: NPORTS must lie in 1..31");
   end
   if (HDR_W != 8) begin : g_bad_width
      $error("rr_route_resolver: header width must be 8");
   end

   logic [NPORTS-1:0] t_ports, t_strip;
   logic              t_mcast, t_adapt;
   logic [NPORTS-1:0] p_onehot;
   logic              p_ok;

   rr_route_table #(.N(NPORTS), .AW(HDR_W), .BASE(LOGICAL_BASE)) u_table (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_we), .waddr(cfg_addr), .wports(cfg_ports), .wstrip(cfg_strip),
      .wmcast(cfg_mcast), .wadapt(cfg_adapt),
      .raddr(hdr_byte), .rports(t_ports), .rstrip(t_strip),
      .rmcast(t_mcast), .radapt(t_adapt)
   );

   rr_path_decode #(.N(NPORTS), .AW(HDR_W)) u_path (
      .addr(hdr_byte), .onehot(p_onehot), .ok(p_ok)
   );

   logic              pend_q;
   logic [NPORTS-1:0] pend_ports_q, pend_strip_q;

   // classify the incoming header
   logic              is_logical, multi_bit;
   route_kind_e       new_kind;
   logic [NPORTS-1:0] new_ports, new_strip;

   assign is_logical = hdr_byte >= HDR_W'(LOGICAL_BASE);
   assign multi_bit  = (t_ports & (t_ports - 1'b1)) != '0;

   always_comb begin
      new_ports = '0;
      new_strip = '0;
      new_kind  = KIND_BAD;
      if (!is_logical) begin
         if (p_ok) begin
            new_ports = p_onehot;
            new_strip = p_onehot;
            new_kind  = KIND_UNICAST;
         end
      end else if (t_ports == '0 || (t_mcast && t_adapt)) begin
         new_kind = KIND_BAD;
      end else if (t_adapt) begin
         new_ports = t_ports;
         new_strip = t_strip & t_ports;
         new_kind  = KIND_ADAPTIVE;
      end else if (t_mcast) begin
         new_ports = t_ports;
         new_strip = t_strip & t_ports;
         new_kind  = KIND_MULTI;
      end else if (!multi_bit) begin
         new_ports = t_ports;
         new_strip = t_strip & t_ports;
         new_kind  = KIND_UNICAST;
      end
   end

   // adaptive selection works on the pending group or the new one
   logic [NPORTS-1:0] grp_ports, grp_strip, pick;
   logic              pick_any;

   assign grp_ports = pend_q ? pend_ports_q : new_ports;
   assign grp_strip = pend_q ? pend_strip_q : new_strip;

   rr_pick_first #(.N(NPORTS)) u_pick (
      .req(grp_ports & port_avail), .grant(pick), .any(pick_any)
   );

   logic accept;
   assign accept    = hdr_valid && !pend_q;
   assign hdr_ready = !pend_q;

   logic              o_valid_d, o_inv_d, o_mc_d, o_ad_d, pend_d;
   logic [NPORTS-1:0] o_ports_d, o_strip_d;

   always_comb begin
      o_valid_d = 1'b0;
      o_inv_d   = 1'b0;
      o_mc_d    = 1'b0;
      o_ad_d    = 1'b0;
      o_ports_d = '0;
      o_strip_d = '0;
      pend_d    = pend_q;
      if (pend_q) begin
         if (pick_any) begin
            o_valid_d = 1'b1;
            o_ad_d    = 1'b1;
            o_ports_d = pick;
            o_strip_d = grp_strip & pick;
            pend_d    = 1'b0;
         end
      end else if (accept) begin
         unique case (new_kind)
            KIND_BAD: begin
               o_valid_d = 1'b1;
               o_inv_d   = 1'b1;
            end
            KIND_ADAPTIVE: begin
               if (pick_any) begin
                  o_valid_d = 1'b1;
                  o_ad_d    = 1'b1;
                  o_ports_d = pick;
                  o_strip_d = grp_strip & pick;
               end else begin
                  pend_d = 1'b1;
               end
            end
            KIND_MULTI: begin
               o_valid_d = 1'b1;
               o_mc_d    = 1'b1;
               o_ports_d = new_ports;
               o_strip_d = new_strip;
            end
            default: begin
               o_valid_d = 1'b1;
               o_ports_d = new_ports;
               o_strip_d = new_strip;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q        <= 1'b0;
         pend_ports_q  <= '0;
         pend_strip_q  <= '0;
         route_valid   <= 1'b0;
         route_invalid <= 1'b0;
         route_mcast   <= 1'b0;
         route_adapt   <= 1'b0;
         route_ports   <= '0;
         route_strip   <= '0;
      end else begin
         pend_q        <= pend_d;
         if (accept) begin
            pend_ports_q <= new_ports;
            pend_strip_q <= new_strip;
         end
         route_valid   <= o_valid_d;
         route_invalid <= o_inv_d;
         route_mcast   <= o_mc_d;
         route_adapt   <= o_ad_d;
         route_ports   <= o_ports_d;
         route_strip   <= o_strip_d;
      end
   end
endmodule

// File: rtl/rr_route_checker.sv
module rr_route_checker #(
   parameter int unsigned NPORTS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_valid,
   input logic              hdr_ready,
   input logic [NPORTS-1:0] port_avail,
   input logic              route_valid,
   input logic              route_invalid,
   input logic [NPORTS-1:0] route_ports,
   input logic [NPORTS-1:0] route_strip,
   input logic              route_mcast,
   input logic              route_adapt
);
   a_r5_adapt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid && route_adapt |-> $countones(route_ports) == 1);

   a_r5_adapt_was_free: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid && route_adapt |-> (route_ports & $past(port_avail)) != '0);

   a_r10_strip_in_set: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> (route_strip & ~route_ports) == '0);

   a_r7_invalid_clean: assert property (@(posedge clk) disable iff (!rst_n)
      route_invalid |-> route_valid && route_ports == '0 && route_strip == '0
                        && !route_mcast && !route_adapt);

   a_r7_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(route_mcast && route_adapt));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !route_valid |-> route_ports == '0 && route_strip == '0 && !route_invalid
                       && !route_mcast && !route_adapt);

   a_r6_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready |=> route_valid || !hdr_ready);

   a_r6_pending_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_ready |-> !route_valid);
endmodule

bind rr_route_resolver rr_route_checker #(.NPORTS(NPORTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
   .port_avail(port_avail), .route_valid(route_valid),
   .route_invalid(route_invalid), .route_ports(route_ports),
   .route_strip(route_strip), .route_mcast(route_mcast),
   .route_adapt(route_adapt)
);

// File: tb/tb_rr_route_resolver.sv
`timescale 1ns/1ps
module tb_rr_route_resolver;
   localparam int N  = 8;
   localparam int PW = 2 * N + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hdr_valid = 1'b0;
   logic [7:0] hdr_byte = '0;
   logic hdr_ready;
   logic cfg_we = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [N-1:0] cfg_ports = '0, cfg_strip = '0;
   logic cfg_mcast = 1'b0, cfg_adapt = 1'b0;
   logic [N-1:0] port_avail = '0;
   logic route_valid, route_invalid, route_mcast, route_adapt;
   logic [N-1:0] route_ports, route_strip;

   always #10 clk = ~clk;

   rr_route_resolver #(.NPORTS(N)) dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
      .hdr_ready(hdr_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_ports(cfg_ports), .cfg_strip(cfg_strip), .cfg_mcast(cfg_mcast),
      .cfg_adapt(cfg_adapt), .port_avail(port_avail),
      .route_valid(route_valid), .route_invalid(route_invalid),
      .route_ports(route_ports), .route_strip(route_strip),
      .route_mcast(route_mcast), .route_adapt(route_adapt)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [N-1:0] m_ports [256];
   logic [N-1:0] m_strip [256];
   logic         m_mc [256];
   logic         m_ad [256];

   task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                      input logic [PW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] observed();
      return {route_valid, route_invalid, route_mcast, route_adapt, route_ports, route_strip};
   endfunction

   function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
      return '0;
   endfunction

   function automatic bit bad_entry(input logic [7:0] b);
      int c = $countones(m_ports[b]);
      return (c == 0) || (m_mc[b] && m_ad[b]) || (!m_mc[b] && !m_ad[b] && c > 1);
   endfunction

   function automatic bit will_pend(input logic [7:0] b, input logic [N-1:0] av);
      return b >= 32 && !bad_entry(b) && m_ad[b] && ((m_ports[b] & av) == '0);
   endfunction

   function automatic logic [PW-1:0] expect_of(input logic [7:0] b, input logic [N-1:0] av);
      logic [N-1:0] q;
      if (b < 32) begin
         if (b < N) return {4'b1000, N'(1) << b, N'(1) << b};
         return {4'b1100, {N{1'b0}}, {N{1'b0}}};
      end
      if (bad_entry(b)) return {4'b1100, {N{1'b0}}, {N{1'b0}}};
      if (m_ad[b]) begin
         q = lowest(m_ports[b] & av);
         return {4'b1001, q, m_strip[b] & q};
      end
      return {2'b10, m_mc[b], 1'b0, m_ports[b], m_strip[b] & m_ports[b]};
   endfunction

   task automatic clear_model();
      for (int a = 0; a < 256; a++) begin
         m_ports[a] = '0; m_strip[a] = '0; m_mc[a] = 1'b0; m_ad[a] = 1'b0;
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [N-1:0] p, input logic [N-1:0] s,
                     input logic mc, input logic ad);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_ports = p; cfg_strip = s;
      cfg_mcast = mc; cfg_adapt = ad;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a >= 32) begin
         m_ports[a] = p; m_strip[a] = s; m_mc[a] = mc; m_ad[a] = ad;
      end
   endtask

   // lookup; if it parks as pending, release it with av_after
   task automatic look(input logic [7:0] b, input logic [N-1:0] av,
                       input logic [N-1:0] av_after, input string req);
      logic [PW-1:0] e;
      @(negedge clk);
      hdr_valid = 1'b1; hdr_byte = b; port_avail = av;
      if (will_pend(b, av)) begin
         @(negedge clk);
         chk(!route_valid && !hdr_ready, "R6 pending holds", observed(), '0);
         hdr_byte = 8'd0;  // stray header while not ready
         @(negedge clk);
         chk(!route_valid && !hdr_ready, "R6 re-evaluated still pending", observed(), '0);
         port_avail = av_after;
         e = expect_of(b, av_after);
         @(negedge clk);
         hdr_valid = 1'b0;
         chk(observed() == e, {req, " R6 released"}, observed(), e);
         @(negedge clk);
         chk(!route_valid && hdr_ready, "R6 stray header ignored", observed(), '0);
      end else begin
         e = expect_of(b, av);
         @(negedge clk);
         hdr_valid = 1'b0;
         chk(observed() == e, req, observed(), e);
         @(negedge clk);
         chk(!route_valid, "R10 single pulse", observed(), '0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [PW-1:0] e;
      void'($urandom(32'd7341));
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!route_valid && hdr_ready, "R1 reset outputs", observed(), '0);
      look(8'd100, '1, '1, "R1 empty table");
      look(8'd255, '1, '1, "R1 empty table top");
      // R2 path addresses
      look(8'd0, '0, '0, "R2 path 0");
      look(8'd7, '0, '0, "R2 path 7");
      // R3
      look(8'd8, '1, '1, "R3 path beyond ports");
      look(8'd31, '1, '1, "R3 path 31");
      // R4 multicast, strip masked by set
      wr(8'd40, 8'b0001_0110, 8'b1000_0110, 1'b1, 1'b0);
      look(8'd40, '0, '0, "R4 multicast");
      // R5 adaptive lowest free
      wr(8'd50, 8'b1101_0000, 8'b1001_0000, 1'b0, 1'b1);
      look(8'd50, 8'b0101_0000, '1, "R5 lowest free is 4");
      look(8'd50, 8'b1010_0000, '1, "R5 lowest free is 7");
      // R6 pending then release on port 7
      look(8'd50, 8'b0000_1111, 8'b1000_0000, "R6 wait");
      // R7
      wr(8'd60, 8'b0, 8'hFF, 1'b1, 1'b0);
      wr(8'd61, 8'b0000_0011, 8'b0, 1'b1, 1'b1);
      wr(8'd62, 8'b0000_0011, 8'b0, 1'b0, 1'b0);
      wr(8'd63, 8'b0010_0000, 8'b0010_0001, 1'b0, 1'b0);
      look(8'd60, '1, '1, "R7 empty set");
      look(8'd61, '1, '1, "R7 both flags");
      look(8'd62, '1, '1, "R7 plain multi-port");
      look(8'd63, '1, '1, "R7 plain unicast");
      // R8 same-cycle write and lookup
      e = expect_of(8'd40, '0);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'd40; cfg_ports = 8'b0000_0001; cfg_strip = '0;
      cfg_mcast = 1'b0; cfg_adapt = 1'b0;
      hdr_valid = 1'b1; hdr_byte = 8'd40;
      @(negedge clk);
      cfg_we = 1'b0; hdr_valid = 1'b0;
      chk(observed() == e, "R8 old contents", observed(), e);
      m_ports[40] = 8'b0000_0001; m_strip[40] = '0; m_mc[40] = 1'b0; m_ad[40] = 1'b0;
      look(8'd40, '0, '0, "R8 new contents later");
      // R9 writes below 32 ignored
      wr(8'd3, 8'b1111_0000, 8'b0, 1'b1, 1'b0);
      look(8'd3, '0, '0, "R9 path 3 unchanged");
      wr(8'd20, 8'b0000_0001, 8'b0, 1'b0, 1'b0);
      look(8'd20, '0, '0, "R9 path 20 still invalid");
      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [7:0] a;
         int kind;
         a = ($urandom % 4 == 0) ? 8'($urandom % 40) : 8'(32 + $urandom % 24);
         if ($urandom % 3 == 0) begin
            kind = $urandom % 4;
            wr(a, N'($urandom), N'($urandom), kind == 1 || kind == 3, kind == 2 || kind == 3);
         end else begin
            look(a, N'($urandom), '1, "R4 R5 R7 random lookup");
         end
      end
      // R1 reset clears table
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      clear_model();
      look(8'd50, '1, '1, "R1 table cleared by reset");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule